// File: doc/BRIEF.md
# Data-Address Watchpoint Comparator Bank

A bank of `NUM_SLOTS` data watchpoints for a processor debug unit. Every slot holds an address value word and a control word, both loaded through a register-write port. Each data access on the access port (address, direction, privilege) is compared against all enabled slots in parallel. The lowest-numbered matching slot wins. One cycle later the bank reports a hit, the winning slot number and a reconstructed address.

A slot runs in one of two modes. In lane mode it watches any subset of the eight bytes of one doubleword. In range mode it watches an aligned power-of-two region of 2 to 2^31 bytes. The bank also reports, combinationally from its registers, the lowest slot that is currently disabled, so debug software can find a free slot to allocate.

Top module: `wp_bank`

## Requirements
- R1: After reset, every value and control word is zero, `hit_o` is low, `free_o` is high and `free_idx_o` is 0.
- R2: A write with `wr_sel_i`=0 loads the value word of slot `wr_idx_i`, and a write with `wr_sel_i`=1 loads its control word from `wr_data_i[31:0]`. The new contents take effect at the next clock edge, so an access in the same cycle as the write is judged against the old contents.
- R3: Control bit 0 enables the slot. A disabled slot never matches.
- R4: Control bit 3 allows matching on reads (`acc_write_i`=0) and bit 4 allows matching on writes (`acc_write_i`=1). An access whose direction bit is clear does not match.
- R5: When control bits 2:1 equal 2'b10, only accesses with `acc_user_i`=1 match. Any other value places no privilege restriction.
- R6: Lane mode applies when control bits 28:24 are zero. The slot matches when access address bits 48:3 equal value bits 48:3 and control bit 5+`acc_addr_i[2:0]` is set.
- R7: A lane-mode slot whose lane field (control bits 12:5) is all zero never matches.
- R8: Range mode applies when control bits 28:24 hold a nonzero m (1..31). The slot matches when access address bits 48:m equal value bits 48:m.
- R9: A range-mode slot matches only when all eight lane bits 12:5 are set.
- R10: When several slots match, `hit_idx_o` reports the lowest-numbered one.
- R11: On a lane-mode hit, `hit_addr_o` equals value bits 48:3 with three zero bits appended, plus the index of the lowest set lane bit. On a range-mode hit, `hit_addr_o` equals the access address.
- R12: `hit_o`, `hit_idx_o` and `hit_addr_o` are registered and show the result of an access one cycle after it is sampled. `hit_o` is low in any cycle whose sampled access matched no slot.
- R13: `free_o` is high when at least one slot is disabled, and `free_idx_o` then names the lowest-numbered disabled slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: value word, 1: control word |
| wr_idx_i | input | IDX_W | Slot to write |
| wr_data_i | input | ADDR_W | Write data (control uses bits 31:0) |
| acc_valid_i | input | 1 | Data access present |
| acc_addr_i | input | ADDR_W | Access byte address |
| acc_write_i | input | 1 | 1 for a write access, 0 for a read |
| acc_user_i | input | 1 | Access is made in user mode |
| hit_o | output | 1 | Registered hit flag |
| hit_idx_o | output | IDX_W | Winning slot number |
| hit_addr_o | output | ADDR_W | Reconstructed hit address |
| free_o | output | 1 | Some slot is disabled |
| free_idx_o | output | IDX_W | Lowest disabled slot |

## Verification
Hit results are due exactly one clock edge after the access is sampled. The bench drives each access on a falling edge and reads `hit_o`, `hit_idx_o` and `hit_addr_o` on the next falling edge, then compares them with a model computed from the requirements. Register writes land on the rising edge between two falling edges, so the free-slot outputs are checked one falling edge after the write. One test drives a write and an access in the same cycle to show that the access sees the old contents. Lane patterns are swept across all eight offsets and both directions, and range mode is swept across every mask value from 1 to 31, probing the first and last byte of each region and the bytes just outside it.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned CTRL_W      = 32;
  localparam int unsigned LANES       = 8;
  localparam int unsigned LANE_IDX_W  = 3;
  localparam int unsigned MASK_W      = 5;
  localparam int unsigned CB_EN       = 0;
  localparam int unsigned CB_PRIV     = 1;
  localparam int unsigned CB_LOAD     = 3;
  localparam int unsigned CB_STORE    = 4;
  localparam int unsigned CB_LANE     = 5;
  localparam int unsigned CB_MASK     = 24;

  typedef enum logic [1:0] {
    PRIV_ANY  = 2'b00,
    PRIV_SUP  = 2'b01,
    PRIV_USER = 2'b10,
    PRIV_BOTH = 2'b11
  } priv_sel_e;

  typedef struct packed {
    logic                en;
    logic                user_only;
    logic                on_load;
    logic                on_store;
    logic [LANES-1:0]    lanes;
    logic [MASK_W-1:0]   mask;
  } slot_ctrl_t;

  function automatic slot_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] c);
    slot_ctrl_t d;
    d.en        = c[CB_EN];
    d.user_only = (priv_sel_e'(c[CB_PRIV +: 2]) == PRIV_USER);
    d.on_load   = c[CB_LOAD];
    d.on_store  = c[CB_STORE];
    d.lanes     = c[CB_LANE +: LANES];
    d.mask      = c[CB_MASK +: MASK_W];
    return d;
  endfunction
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
  import wp_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ADDR_W    = 49,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o [NUM_SLOTS],
  output logic [ADDR_W-1:0] val_o  [NUM_SLOTS]
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic sel_c;
    assign sel_c = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_o[g] <= '0;
        val_o[g]  <= '0;
      end else if (sel_c) begin
        if (wr_sel_i) ctrl_o[g] <= wr_data_i[CTRL_W-1:0];
        else          val_o[g]  <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/wp_slot_match.sv
module wp_slot_match
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 49
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [ADDR_W-1:0] val_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_user_i,
  output logic              match_o,
  output logic [ADDR_W-1:0] rep_addr_o
);
  slot_ctrl_t            ctl;
  logic                  range_mode;
  logic [ADDR_W-1:0]     care;
  logic                  region_ok, lane_ok, dir_ok, priv_ok;
  logic [LANE_IDX_W-1:0] first_lane;
  logic                  unused_ctrl;

  assign ctl         = decode_ctrl(ctrl_i);
  assign unused_ctrl = ^{ctrl_i[CTRL_W-1:CB_MASK+MASK_W], ctrl_i[CB_MASK-1:CB_LANE+LANES]};
  assign range_mode  = (ctl.mask != '0);

  // low bits excluded from the address comparison
  assign care = range_mode ? ({ADDR_W{1'b1}} << ctl.mask)
                           : ({ADDR_W{1'b1}} << LANE_IDX_W);

  assign region_ok = (((acc_addr_i ^ val_i) & care) == '0);
  assign lane_ok   = range_mode ? (&ctl.lanes)
                                : ctl.lanes[acc_addr_i[LANE_IDX_W-1:0]];
  assign dir_ok    = acc_write_i ? ctl.on_store : ctl.on_load;
  assign priv_ok   = !ctl.user_only || acc_user_i;
  assign match_o   = acc_valid_i && ctl.en && dir_ok && priv_ok && region_ok && lane_ok;

  always_comb begin
    first_lane = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (ctl.lanes[l]) first_lane = LANE_IDX_W'(l);
    end
  end

  assign rep_addr_o = range_mode
      ? acc_addr_i
      : ({val_i[ADDR_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}} + ADDR_W'(first_lane));
endmodule

// File: rtl/wp_first_set.sv
module wp_first_set #(
  parameter int unsigned N     = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  assign found_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wp_bank.sv
module wp_bank
  import wp_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ADDR_W    = 49,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_user_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [ADDR_W-1:0] hit_addr_o,
  output logic              free_o,
  output logic [IDX_W-1:0]  free_idx_o
);
  logic [CTRL_W-1:0]    ctrl_q [NUM_SLOTS];
  logic [ADDR_W-1:0]    val_q  [NUM_SLOTS];
  logic [ADDR_W-1:0]    rep_addr [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_hit;
  logic [NUM_SLOTS-1:0] slot_en;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;

  wp_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl_q),
    .val_o     (val_q)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign slot_en[g] = ctrl_q[g][CB_EN];

    wp_slot_match #(.ADDR_W(ADDR_W)) u_match (
      .ctrl_i      (ctrl_q[g]),
      .val_i       (val_q[g]),
      .acc_valid_i (acc_valid_i),
      .acc_addr_i  (acc_addr_i),
      .acc_write_i (acc_write_i),
      .acc_user_i  (acc_user_i),
      .match_o     (slot_hit[g]),
      .rep_addr_o  (rep_addr[g])
    );
  end

  wp_first_set #(.N(NUM_SLOTS)) u_hit_pick (
    .req_i   (slot_hit),
    .found_o (any_hit),
    .idx_o   (win_idx)
  );

  wp_first_set #(.N(NUM_SLOTS)) u_free_pick (
    .req_i   (~slot_en),
    .found_o (free_o),
    .idx_o   (free_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o      <= 1'b0;
      hit_idx_o  <= '0;
      hit_addr_o <= '0;
    end else begin
      hit_o <= any_hit;
      if (any_hit) begin
        hit_idx_o  <= win_idx;
        hit_addr_o <= rep_addr[win_idx];
      end
    end
  end
endmodule

// File: rtl/wp_bank_chk.sv
module wp_bank_chk #(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 acc_valid_i,
  input logic                 hit_o,
  input logic [IDX_W-1:0]     hit_idx_o,
  input logic                 free_o,
  input logic [IDX_W-1:0]     free_idx_o,
  input logic [NUM_SLOTS-1:0] slot_hit,
  input logic [NUM_SLOTS-1:0] slot_en
);
  logic [NUM_SLOTS-1:0] below_win;
  assign below_win = (NUM_SLOTS'(1) << hit_idx_o) - NUM_SLOTS'(1);

  a_r12_hit_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(acc_valid_i));

  a_r12_match_reported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(|slot_hit) |-> hit_o);

  a_r10_winner_matched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((($past(slot_hit) >> hit_idx_o) & NUM_SLOTS'(1)) != '0));

  a_r10_none_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (($past(slot_hit) & below_win) == '0));

  a_r3_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_hit & ~slot_en) == '0);

  a_r13_free_is_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o |-> !slot_en[free_idx_o]);

  a_r13_full_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !free_o |-> (&slot_en));
endmodule

bind wp_bank wp_bank_chk #(.NUM_SLOTS(NUM_SLOTS)) u_wp_bank_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .hit_o       (hit_o),
  .hit_idx_o   (hit_idx_o),
  .free_o      (free_o),
  .free_idx_o  (free_idx_o),
  .slot_hit    (slot_hit),
  .slot_en     (slot_en)
);

// File: tb/wp_bank_bench.sv
module wp_bank_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  NS = 4;
  localparam int  AW = 49;
  localparam int  IW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [IW-1:0] wr_idx_i = '0;
  logic [AW-1:0] wr_data_i = '0;
  logic          acc_valid_i = 1'b0, acc_write_i = 1'b0, acc_user_i = 1'b0;
  logic [AW-1:0] acc_addr_i = '0;
  logic          hit_o, free_o;
  logic [IW-1:0] hit_idx_o, free_idx_o;
  logic [AW-1:0] hit_addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0]   m_ctrl [NS];
  logic [AW-1:0] m_val  [NS];
  logic          e_hit;
  int            e_idx;
  logic [AW-1:0] e_addr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wp_bank #(.NUM_SLOTS(NS), .ADDR_W(AW)) u_wp_bank (.*);

  function automatic logic [31:0] mk_ctrl(bit en, bit [1:0] priv, bit ld, bit st,
                                          bit [7:0] lanes, bit [4:0] mask);
    return {3'b0, mask, 11'b0, lanes, st, ld, priv, en};
  endfunction

  // expected result from the requirements
  task automatic model(input logic [AW-1:0] a, input bit wr, input bit usr);
    e_hit = 1'b0; e_idx = 0; e_addr = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      logic [31:0] c;
      int m;
      bit ok;
      c = m_ctrl[s];
      m = int'(c[28:24]);
      ok = c[0] && (wr ? c[4] : c[3]) && !(c[2:1] == 2'b10 && !usr);
      if (m == 0) begin
        ok = ok && (a[AW-1:3] == m_val[s][AW-1:3]) && c[5 + int'(a[2:0])];
      end else begin
        ok = ok && ((a >> m) == (m_val[s] >> m)) && (c[12:5] == 8'hff);
      end
      if (ok) begin
        e_hit = 1'b1; e_idx = s;
        if (m == 0) begin
          int lo;
          lo = 0;
          for (int l = 7; l >= 0; l--) if (c[5 + l]) lo = l;
          e_addr = {m_val[s][AW-1:3], 3'b000} + AW'(lo);
        end else begin
          e_addr = a;
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input bit sel, input logic [AW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_idx_i = IW'(idx); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (sel) m_ctrl[idx] = d[31:0];
    else     m_val[idx]  = d;
  endtask

  task automatic probe(input logic [AW-1:0] a, input bit wr, input bit usr, input string req);
    @(negedge clk_i);
    model(a, wr, usr);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_write_i = wr; acc_user_i = usr;
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    check(hit_o == e_hit, req, "hit", longint'(hit_o), longint'(e_hit));
    if (e_hit && hit_o) begin
      check(int'(hit_idx_o) == e_idx, req, "idx", longint'(hit_idx_o), longint'(e_idx));
      check(hit_addr_o == e_addr, req, "addr", longint'(hit_addr_o), longint'(e_addr));
    end
  endtask

  task automatic clear_all();
    for (int s = 0; s < NS; s++) begin
      wr_reg(s, 1'b1, '0);
      wr_reg(s, 1'b0, '0);
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin m_ctrl[s] = '0; m_val[s] = '0; end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(hit_o == 1'b0, "R1", "hit", longint'(hit_o), 0);
    check(free_o == 1'b1, "R1", "free", longint'(free_o), 1);
    check(free_idx_o == '0, "R1", "free_idx", longint'(free_idx_o), 0);
    rst_ni = 1'b1;
    probe(49'h0, 1'b0, 1'b1, "R1");

    // R6 R11 lane mode sweep
    begin
      logic [7:0] pats [3];
      pats[0] = 8'h01; pats[1] = 8'ha4; pats[2] = 8'hff;
      wr_reg(0, 1'b0, 49'h1_2345_6780);
      for (int p = 0; p < 3; p++) begin
        wr_reg(0, 1'b1, AW'(mk_ctrl(1, 2'b00, 1, 1, pats[p], 0)));
        for (int off = 0; off < 8; off++)
          for (int w = 0; w < 2; w++)
            probe(49'h1_2345_6780 + AW'(off), w[0], 1'b0, "R6_R11");
        probe(49'h1_2345_6788, 1'b0, 1'b0, "R6");
        probe(49'h1_2345_6778, 1'b1, 1'b0, "R6");
      end
    end

    // R7 empty lane field
    wr_reg(0, 1'b1, AW'(mk_ctrl(1, 2'b00, 1, 1, 8'h00, 0)));
    for (int off = 0; off < 8; off++) probe(49'h1_2345_6780 + AW'(off), 1'b0, 1'b0, "R7");

    // R4 direction
    wr_reg(0, 1'b1, AW'(mk_ctrl(1, 2'b00, 1, 0, 8'hff, 0)));
    probe(49'h1_2345_6781, 1'b0, 1'b0, "R4");
    probe(49'h1_2345_6781, 1'b1, 1'b0, "R4");
    wr_reg(0, 1'b1, AW'(mk_ctrl(1, 2'b00, 0, 1, 8'hff, 0)));
    probe(49'h1_2345_6781, 1'b0, 1'b0, "R4");
    probe(49'h1_2345_6781, 1'b1, 1'b0, "R4");

    // R5 privilege
    for (int pv = 0; pv < 4; pv++) begin
      wr_reg(0, 1'b1, AW'(mk_ctrl(1, pv[1:0], 1, 1, 8'hff, 0)));
      probe(49'h1_2345_6782, 1'b0, 1'b0, "R5");
      probe(49'h1_2345_6782, 1'b0, 1'b1, "R5");
    end

    // R3 disabled
    wr_reg(0, 1'b1, AW'(mk_ctrl(0, 2'b00, 1, 1, 8'hff, 0)));
    probe(49'h1_2345_6783, 1'b1, 1'b1, "R3");
    clear_all();

    // R8 R11 range mode sweep on slot 1
    wr_reg(1, 1'b0, 49'h1_0000_0000);
    for (int m = 1; m < 32; m++) begin
      wr_reg(1, 1'b1, AW'(mk_ctrl(1, 2'b00, 1, 1, 8'hff, m[4:0])));
      probe(49'h1_0000_0000, 1'b1, 1'b0, "R8");
      probe(49'h1_0000_0000 + (AW'(1) << m) - AW'(1), 1'b0, 1'b0, "R8_R11");
      probe(49'h1_0000_0000 + (AW'(1) << m), 1'b0, 1'b0, "R8");
      probe(49'h0_FFFF_FFFF, 1'b1, 1'b0, "R8");
    end

    // R9 range mode with partial lanes
    wr_reg(1, 1'b1, AW'(mk_ctrl(1, 2'b00, 1, 1, 8'h7f, 5'd4)));
    probe(49'h1_0000_0003, 1'b0, 1'b0, "R9");
    clear_all();

    // R10 priority and R13 free index
    for (int s = 0; s < NS; s++) begin
      wr_reg(s, 1'b0, 49'h2000);
      wr_reg(s, 1'b1, AW'(mk_ctrl(1, 2'b00, 1, 1, 8'h0f << s, 0)));
      @(negedge clk_i);
      check(free_o == (s != NS - 1), "R13", "free", longint'(free_o), longint'(s != NS - 1));
      if (s != NS - 1)
        check(int'(free_idx_o) == s + 1, "R13", "free_idx", longint'(free_idx_o), longint'(s + 1));
    end
    for (int off = 0; off < 8; off++) probe(49'h2000 + AW'(off), 1'b0, 1'b0, "R10");
    wr_reg(1, 1'b1, '0);
    @(negedge clk_i);
    check(free_o && free_idx_o == 2'd1, "R13", "free_idx", longint'(free_idx_o), 1);
    for (int off = 0; off < 8; off++) probe(49'h2000 + AW'(off), 1'b1, 1'b0, "R10");
    clear_all();

    // R2 same-cycle write and access sees old contents
    wr_reg(2, 1'b0, 49'h3000);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_idx_i = 2'd2;
    wr_data_i = AW'(mk_ctrl(1, 2'b00, 1, 1, 8'hff, 0));
    acc_valid_i = 1'b1; acc_addr_i = 49'h3004; acc_write_i = 1'b0; acc_user_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0; acc_valid_i = 1'b0;
    m_ctrl[2] = mk_ctrl(1, 2'b00, 1, 1, 8'hff, 0);
    check(hit_o == 1'b0, "R2", "old contents", longint'(hit_o), 0);
    probe(49'h3004, 1'b0, 1'b0, "R2");
    // R2 value word selection
    wr_reg(2, 1'b0, 49'h4000);
    probe(49'h3004, 1'b0, 1'b0, "R2");
    probe(49'h4005, 1'b0, 1'b0, "R2");

    // R12 result held for a single cycle
    probe(49'h4001, 1'b1, 1'b0, "R12");
    @(negedge clk_i);
    check(hit_o == 1'b0, "R12", "hit after idle", longint'(hit_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule